// File: doc/BRIEF.md
# Register-Register Integer Core (single cycle)

This block is a minimal 32-bit processor. It runs only register-to-register integer instructions. A program counter addresses a small internal instruction memory. The fetched word is split into its source, destination and function fields. Two operands are read from a 32-entry register file. A combinational ALU produces the result, and the result is written to the destination register on the same clock edge that moves the program counter to the next word. Each instruction therefore takes exactly one cycle.

The core has no immediate forms, so it cannot build constants on its own. The program and the starting register values are both loaded while reset is held. A word-wide write port fills the instruction memory, and a preload port fills the registers. Once reset is released the core runs freely. Words that are not register-register operations retire without effect. An asynchronous debug read port returns the contents of any register for checking.

Top module: `rtype_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter `pc` is 0 after that edge, and it stays 0 until the first rising edge with `rst` low.
- R2: At every rising edge with `rst` low, `pc` increases by 4, whatever word was fetched.
- R3: An instruction word carries funct7 in bits 31:25, rs2 in 24:20, rs1 in 19:15, funct3 in 14:12, rd in 11:7 and the major opcode 0110011 in bits 6:0. With funct3 0, funct7 0x00 writes rs1+rs2 to rd, and funct7 0x20 writes rs1-rs2 to rd, both modulo 2^32.
- R4: With funct7 0x00, funct3 7 writes rs1 AND rs2, funct3 6 writes rs1 OR rs2, and funct3 4 writes rs1 XOR rs2.
- R5: funct3 1 with funct7 0x00 shifts rs1 left and fills with zeros. funct3 5 with funct7 0x00 shifts rs1 right and fills with zeros. funct3 5 with funct7 0x20 shifts rs1 right and replicates the sign bit. The shift amount is rs2 bits 4:0 only.
- R6: With funct7 0x00, funct3 2 writes 1 when rs1 < rs2 as signed values, and 0 otherwise. funct3 3 does the same comparison on unsigned values.
- R7: Register 0 always reads as 0 on every read port, and a write to it is discarded.
- R8: A word with any other major opcode, or with a funct7/funct3 pair not listed in R3 to R6, writes no register. The all-zero word is one such word.
- R9: The instruction memory holds `IMEM_DEPTH` words and is indexed by `pc` bits above bit 1. A `pc` at or beyond `IMEM_DEPTH*4` fetches all zeros, which retires as a no-op.
- R10: A result written at one edge is seen as an operand by the instruction of the next cycle and on `dbg_data` right after that edge.
- R11: While `rst` is high, `imem_we` writes `imem_wdata` to word `imem_waddr` and `rf_ld_we` writes `rf_ld_data` to register `rf_ld_addr` at the rising edge. No instruction writes a register while `rst` is high.
- R12: While `rst` is low, `rf_ld_we` has no effect on the register file.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; load window for program and registers |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_waddr | input | $clog2(IMEM_DEPTH) | Word index to write |
| imem_wdata | input | 32 | Instruction word to store |
| rf_ld_we | input | 1 | Register preload strobe, honoured only during reset |
| rf_ld_addr | input | 5 | Register number to preload |
| rf_ld_data | input | 32 | Preload value |
| dbg_addr | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Asynchronous contents of register `dbg_addr` |
| pc | output | 32 | Current program counter |

## Verification
An instruction fetched while `pc` holds a given value commits at the next rising edge. Both its destination register and `pc + 4` become visible right after that edge, with no further latency, because the debug read is combinational. The bench advances its reference model at each rising edge using only its own state. At the following falling edge it compares `pc`, sets `dbg_addr` to the destination field of the instruction that just retired, and reads `dbg_data` one nanosecond later. Words that should be ignored are checked the same way against the unchanged model value, and a full register dump at the end catches any stray write.

// File: rtl/rtype_pkg.sv
package rtype_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int REG_AW = $clog2(NREG);

    localparam logic [6:0] OPC_REG  = 7'b0110011;
    localparam logic [6:0] F7_BASE  = 7'h00;
    localparam logic [6:0] F7_ALT   = 7'h20;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLL,
        ALU_SLT,
        ALU_SLTU,
        ALU_XOR,
        ALU_SRL,
        ALU_SRA,
        ALU_OR,
        ALU_AND
    } alu_op_e;

    typedef struct packed {
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
        logic [REG_AW-1:0] rd;
        alu_op_e           op;
        logic              wen;
    } dec_t;

    function automatic dec_t decode_word(input logic [XLEN-1:0] w);
        dec_t       d;
        logic [6:0] f7;
        logic [2:0] f3;
        f7    = w[31:25];
        f3    = w[14:12];
        d.rs2 = w[24:20];
        d.rs1 = w[19:15];
        d.rd  = w[11:7];
        d.op  = ALU_ADD;
        d.wen = 1'b0;
        if (w[6:0] == OPC_REG) begin
            case (f3)
                3'd0: begin
                    if (f7 == F7_BASE) begin d.op = ALU_ADD; d.wen = 1'b1; end
                    else if (f7 == F7_ALT) begin d.op = ALU_SUB; d.wen = 1'b1; end
                end
                3'd5: begin
                    if (f7 == F7_BASE) begin d.op = ALU_SRL; d.wen = 1'b1; end
                    else if (f7 == F7_ALT) begin d.op = ALU_SRA; d.wen = 1'b1; end
                end
                default: begin
                    if (f7 == F7_BASE) begin
                        d.wen = 1'b1;
                        case (f3)
                            3'd1:    d.op = ALU_SLL;
                            3'd2:    d.op = ALU_SLT;
                            3'd3:    d.op = ALU_SLTU;
                            3'd4:    d.op = ALU_XOR;
                            3'd6:    d.op = ALU_OR;
                            default: d.op = ALU_AND;
                        endcase
                    end
                end
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/rtype_imem.sv
module rtype_imem
    import rtype_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] instr
);

    logic [XLEN-1:0] mem [DEPTH];
    logic            in_range;
    logic [AW-1:0]   ridx;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign ridx = pc[AW+1:2];

    generate
        if (AW + 2 < XLEN) begin : g_bound
            assign in_range = (pc[XLEN-1:AW+2] == '0);
        end else begin : g_full
            assign in_range = 1'b1;
        end
    endgenerate

    assign instr = in_range ? mem[ridx] : '0;

endmodule

// File: rtl/rtype_decoder.sv
module rtype_decoder
    import rtype_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);

    assign dec = decode_word(instr);

    always_comb begin
        if (instr[6:0] != OPC_REG) begin
            p_nowrite_foreign_r8: assert (!dec.wen);
        end
    end

endmodule

// File: rtl/rtype_alu.sv
module rtype_alu
    import rtype_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] shamt;
    logic           lt_s;
    logic           lt_u;

    assign shamt = b[SHW-1:0];
    assign lt_s  = $signed(a) < $signed(b);
    assign lt_u  = a < b;

    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << shamt;
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, lt_s};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, lt_u};
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> shamt;
            ALU_SRA:  y = $unsigned($signed(a) >>> shamt);
            ALU_OR:   y = a | b;
            ALU_AND:  y = a & b;
            default:  y = '0;
        endcase
    end

    always_comb begin
        if (op == ALU_SLT || op == ALU_SLTU) begin
            p_cmp_boolean_r6: assert (y[XLEN-1:1] == '0);
        end
    end

endmodule

// File: rtl/rtype_regfile.sv
module rtype_regfile
    import rtype_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [REG_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [REG_AW-1:0] ra1,
    output logic [XLEN-1:0]   rd1,
    input  logic [REG_AW-1:0] ra2,
    output logic [XLEN-1:0]   rd2,
    input  logic [REG_AW-1:0] ra3,
    output logic [XLEN-1:0]   rd3
);

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            if (ld_we && ld_addr != '0) regs[ld_addr] <= ld_data;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

    // R10: a committed write is what the array holds one edge later
    p_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/rtype_core.sv
module rtype_core
    import rtype_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    localparam int IAW       = $clog2(IMEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              imem_we,
    input  logic [IAW-1:0]    imem_waddr,
    input  logic [XLEN-1:0]   imem_wdata,
    input  logic              rf_ld_we,
    input  logic [REG_AW-1:0] rf_ld_addr,
    input  logic [XLEN-1:0]   rf_ld_data,
    input  logic [REG_AW-1:0] dbg_addr,
    output logic [XLEN-1:0]   dbg_data,
    output logic [XLEN-1:0]   pc
);

    localparam logic [XLEN-1:0] IMEM_BYTES = XLEN'(IMEM_DEPTH * 4);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] instr;
    dec_t            dec;
    logic [XLEN-1:0] op_a;
    logic [XLEN-1:0] op_b;
    logic [XLEN-1:0] result;
    logic            core_we;
    logic            unused_pc_lsb;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_q + XLEN'(4);
    end

    assign pc            = pc_q;
    assign unused_pc_lsb = ^pc_q[1:0];

    rtype_imem #(.DEPTH(IMEM_DEPTH)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .pc    (pc_q),
        .instr (instr)
    );

    rtype_decoder u_dec (
        .instr (instr),
        .dec   (dec)
    );

    rtype_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .ld_we   (rf_ld_we),
        .ld_addr (rf_ld_addr),
        .ld_data (rf_ld_data),
        .we      (core_we),
        .waddr   (dec.rd),
        .wdata   (result),
        .ra1     (dec.rs1),
        .rd1     (op_a),
        .ra2     (dec.rs2),
        .rd2     (op_b),
        .ra3     (dbg_addr),
        .rd3     (dbg_data)
    );

    rtype_alu u_alu (
        .op (dec.op),
        .a  (op_a),
        .b  (op_b),
        .y  (result)
    );

    assign core_we = dec.wen & ~rst;

    p_pc_reset_r1: assert property (@(posedge clk)
        rst |=> pc_q == '0);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_q == $past(pc_q) + XLEN'(4));

    p_x0_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (dbg_addr == '0) |-> dbg_data == '0);

    p_outside_noop_r9: assert property (@(posedge clk) disable iff (rst)
        (pc_q >= IMEM_BYTES) |-> !core_we);

endmodule

// File: tb/tb_rtype_core.sv
`timescale 1ns/1ps
module tb_rtype_core;

    localparam int DEPTH    = 64;
    localparam int PROG_LEN = 24;
    localparam int RUN_CYC  = 72;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic        rf_ld_we = 1'b0;
    logic [4:0]  rf_ld_addr = '0;
    logic [31:0] rf_ld_data = '0;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_data;
    logic [31:0] pc;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    logic [31:0] prog   [DEPTH];
    logic [31:0] ref_rf [32];
    logic [31:0] ref_pc;

    always #2 clk = ~clk;

    rtype_core #(.IMEM_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .rf_ld_we(rf_ld_we), .rf_ld_addr(rf_ld_addr), .rf_ld_data(rf_ld_data),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data), .pc(pc)
    );

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] s2,
                                        input logic [4:0] s1, input logic [2:0] f3,
                                        input logic [4:0] d);
        return {f7, s2, s1, f3, d, 7'b0110011};
    endfunction

    function automatic logic [31:0] seed(input int i);
        case (i)
            1: return 32'h0000_0007;
            2: return 32'hFFFF_FFF9;
            3: return 32'h8000_0000;
            4: return 32'h0000_0024;
            5: return 32'h1234_5678;
            6: return 32'h0F0F_00FF;
            7: return 32'h0000_0003;
            default: return (32'(i) * 32'h0101_0101) ^ 32'hA500_0000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference: returns write flag, value, and the requirement tag
    task automatic ref_exec(input logic [31:0] w, output bit wr, output logic [31:0] val,
                            output string tag);
        logic [31:0] a, b;
        int sh;
        a   = ref_rf[w[19:15]];
        b   = ref_rf[w[24:20]];
        sh  = int'(b[4:0]);
        wr  = 1'b1;
        val = 32'h0;
        tag = "R8";
        if (w[6:0] != 7'b0110011) wr = 1'b0;
        else if (w[31:25] == 7'h20 && w[14:12] == 3'd0) begin val = a - b; tag = "R3"; end
        else if (w[31:25] == 7'h20 && w[14:12] == 3'd5) begin
            val = $unsigned($signed(a) >>> sh); tag = "R5";
        end else if (w[31:25] != 7'h00) wr = 1'b0;
        else begin
            case (w[14:12])
                3'd0: begin val = a + b;  tag = "R3"; end
                3'd1: begin val = a << sh; tag = "R5"; end
                3'd2: begin val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R6"; end
                3'd3: begin val = (a < b) ? 32'd1 : 32'd0; tag = "R6"; end
                3'd4: begin val = a ^ b;  tag = "R4"; end
                3'd5: begin val = a >> sh; tag = "R5"; end
                3'd6: begin val = a | b;  tag = "R4"; end
                default: begin val = a & b; tag = "R4"; end
            endcase
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) prog[i] = 32'h0;
        prog[0]  = enc(7'h00, 5'd2, 5'd1, 3'd0, 5'd10); // add
        prog[1]  = enc(7'h20, 5'd2, 5'd1, 3'd0, 5'd11); // sub
        prog[2]  = enc(7'h20, 5'd1, 5'd2, 3'd0, 5'd12); // sub negative
        prog[3]  = enc(7'h00, 5'd6, 5'd5, 3'd7, 5'd13); // and
        prog[4]  = enc(7'h00, 5'd6, 5'd5, 3'd6, 5'd14); // or
        prog[5]  = enc(7'h00, 5'd6, 5'd5, 3'd4, 5'd15); // xor
        prog[6]  = enc(7'h00, 5'd7, 5'd5, 3'd1, 5'd16); // sll 3
        prog[7]  = enc(7'h00, 5'd4, 5'd5, 3'd1, 5'd17); // sll, amount from low 5 bits of 0x24
        prog[8]  = enc(7'h00, 5'd7, 5'd3, 3'd5, 5'd18); // srl
        prog[9]  = enc(7'h20, 5'd7, 5'd3, 3'd5, 5'd19); // sra negative
        prog[10] = enc(7'h20, 5'd1, 5'd2, 3'd5, 5'd20); // sra -7 by 7
        prog[11] = enc(7'h00, 5'd1, 5'd2, 3'd2, 5'd21); // slt -7<7
        prog[12] = enc(7'h00, 5'd1, 5'd2, 3'd3, 5'd22); // sltu
        prog[13] = enc(7'h00, 5'd2, 5'd1, 3'd2, 5'd23); // slt
        prog[14] = enc(7'h00, 5'd2, 5'd1, 3'd3, 5'd24); // sltu
        prog[15] = enc(7'h00, 5'd6, 5'd5, 3'd0, 5'd0);  // write to x0
        prog[16] = enc(7'h00, 5'd5, 5'd0, 3'd0, 5'd25); // x0 as operand
        prog[17] = {12'h005, 5'd1, 3'd0, 5'd26, 7'b0010011}; // foreign opcode
        prog[18] = enc(7'h01, 5'd2, 5'd1, 3'd0, 5'd27); // undefined funct7
        prog[19] = enc(7'h20, 5'd2, 5'd1, 3'd7, 5'd28); // undefined pair
        prog[20] = enc(7'h00, 5'd11, 5'd11, 3'd0, 5'd29); // uses x11
        prog[21] = enc(7'h00, 5'd1, 5'd29, 3'd0, 5'd30); // uses x29 just written
        prog[22] = enc(7'h00, 5'd1, 5'd3, 3'd2, 5'd31); // slt min vs 7
        prog[23] = enc(7'h20, 5'd4, 5'd3, 3'd5, 5'd9);  // sra by 4
    end

    initial begin : main
        bit          wr;
        logic [31:0] val;
        string       tag;
        logic [4:0]  prev_rd;
        bit          prev_wr;
        ref_rf[0] = 32'h0;
        for (int i = 1; i < 32; i++) ref_rf[i] = seed(i);
        repeat (3) @(negedge clk);
        check("R1 pc in reset", pc, 32'h0);
        // load window (R11)
        for (int i = 0; i < DEPTH; i++) begin
            imem_we    = 1'b1;
            imem_waddr = 6'(i);
            imem_wdata = prog[i];
            rf_ld_we   = (i >= 1 && i < 32);
            rf_ld_addr = 5'(i);
            rf_ld_data = seed(i);
            @(negedge clk);
        end
        imem_we  = 1'b0;
        rf_ld_we = 1'b0;
        check("R1 pc held during load", pc, 32'h0);
        dbg_addr = 5'd5;
        #1 check("R11 preload visible", dbg_data, seed(5));
        rst = 1'b0;
        #0.5 check("R1 pc at release", pc, 32'h0);
        ref_pc  = 32'h0;
        prev_rd = 5'd0;
        prev_wr = 1'b0;
        for (int c = 0; c < RUN_CYC; c++) begin
            logic [31:0] w;
            logic [31:0] pc_was;
            string       t;
            @(posedge clk);
            pc_was = ref_pc;
            w = (ref_pc < 32'(DEPTH * 4)) ? prog[ref_pc[7:2]] : 32'h0;
            ref_exec(w, wr, val, tag);
            if (wr && w[11:7] != 5'd0) ref_rf[w[11:7]] = val;
            ref_pc = ref_pc + 32'd4;
            @(negedge clk);
            check("R2 pc step", pc, ref_pc);
            if (c == 5) begin
                rf_ld_we   = 1'b1;
                rf_ld_addr = 5'd8;
                rf_ld_data = 32'hDEAD_BEEF;
            end else begin
                rf_ld_we = 1'b0;
            end
            if (w[11:7] == 5'd0)                t = "R7";
            else if (pc_was >= 32'(DEPTH * 4))  t = "R9";
            else if (wr && prev_wr && prev_rd != 5'd0 &&
                     (w[19:15] == prev_rd || w[24:20] == prev_rd)) t = "R10";
            else                                t = tag;
            dbg_addr = w[11:7];
            #1 check({t, " rd after retire"}, dbg_data, ref_rf[w[11:7]]);
            prev_rd = w[11:7];
            prev_wr = wr;
        end
        rf_ld_we = 1'b0;
        for (int i = 0; i < 32; i++) begin
            dbg_addr = 5'(i);
            #1;
            if (i == 0)      check("R7 final x0", dbg_data, 32'h0);
            else if (i == 8) check("R12 load ignored when running", dbg_data, seed(8));
            else             check("R11 final register", dbg_data, ref_rf[i]);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule